// File: doc/BRIEF.md
# Banked Program Memory Mapper with Nibble Table Reader

This block sits between a small nibble-wide CPU core and a 16K x 8 program memory built as four 4K banks. A 13-bit CPU fetch address is turned into a 14-bit physical address. The lower 4K of the CPU space is fixed to bank 0. The upper 4K is a window onto bank 1, 2 or 3, and a 2-bit bank select register picks which one.

The block also holds a 12-bit table pointer. The CPU loads it four bits at a time from its accumulator. The pointer then indexes a byte inside whichever upper bank is selected, and that byte goes out on a second physical address port. A low-nibble read returns bits 3:0 of the byte and leaves the pointer alone. A high-nibble read returns bits 7:4 and advances the pointer by one, so a byte stream can be walked two reads per byte. The returned nibble is registered and is valid in the cycle after the read strobe.

The memory array itself is outside the block. The fetch port is combinational, and the table data comes back combinationally from the table address.

Top module: `rbl_top`

## Requirements
- R1: When fetch address bit 12 is 0, the fetch physical address is {2'b00, fetch_addr[11:0]}.
- R2: When fetch address bit 12 is 1, the physical bank field (bits 13:12) is select+1 for select values 0, 1 and 2. The offset is fetch_addr[11:0]. Select resets to 0, so bank 1 is mapped after reset.
- R3: Select value 3 is reserved. It maps the upper half and the table port to bank 3, and it sets the sticky flag bank_err one cycle after the write. Only reset clears bank_err, and bank_err is 0 after reset.
- R4: The pointer resets to 000h. A pointer write loads ptr_din into one nibble and leaves the other nibbles unchanged. The field code on ptr_fld selects the nibble: 0 loads bits 3:0, 1 loads bits 7:4, 2 loads bits 11:8, and 3 changes nothing.
- R5: The table physical address is {bank, pointer}, where bank is the select+1 mapping of R2/R3. It is never bank 0.
- R6: A low read (rd_lo) makes nib_out equal to bits 3:0 of the addressed byte in the next cycle, and leaves the pointer unchanged.
- R7: A high read (rd_hi) makes nib_out equal to bits 7:4 of the addressed byte in the next cycle, and increments the pointer. The increment wraps from FFFh to 000h and never changes the bank select.
- R8: When a pointer write and rd_hi occur in the same cycle, the write wins and no increment happens. When rd_hi and rd_lo occur together, the high read is performed.
- R9: nib_out is 0 after reset and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Write strobe for the bank select |
| bank_din | input | 2 | New bank select value |
| fetch_addr | input | 13 | CPU instruction fetch address |
| fetch_paddr | output | 14 | Physical fetch address |
| ptr_we | input | 1 | Pointer nibble write strobe |
| ptr_fld | input | 2 | Pointer nibble field code |
| ptr_din | input | 4 | Nibble from the accumulator |
| rd_lo | input | 1 | Low-nibble table read strobe |
| rd_hi | input | 1 | High-nibble table read strobe, post-increments the pointer |
| tbl_paddr | output | 14 | Physical table read address |
| tbl_data | input | 8 | Byte returned by memory for tbl_paddr |
| nib_out | output | 4 | Registered nibble returned to the CPU |
| bank_err | output | 1 | Sticky flag for a reserved select value |

## Verification
A corrupted bank select shows up at once in the fetch address of every upper-half access, and in the bank field of the table address in the same cycle. The bench therefore sweeps fetch addresses under each select value. A wrong pointer shows up directly in tbl_paddr bits 11:0, and one cycle later in nib_out. Long chains of high reads, including a pass across FFFh, expose a wrong increment or wrap at the first byte it affects. A lost or self-clearing error flag shows on bank_err in the cycle after the reserved write, or in the cycle after any later write.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
   localparam int unsigned RBL_SEL_W = 2;
   localparam int unsigned RBL_OFF_W = 12;
   localparam int unsigned RBL_NIB_W = 4;

   typedef enum logic [1:0] {
      FLD_LOW  = 2'd0,
      FLD_MID  = 2'd1,
      FLD_HIGH = 2'd2,
      FLD_NONE = 2'd3
   } ptr_fld_e;
endpackage

// File: rtl/rbl_bank_reg.sv
module rbl_bank_reg #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] din,
   output logic [SEL_W-1:0] sel,
   output logic             err
);
   localparam logic [SEL_W-1:0] RESERVED = '1;

   initial begin
      if (SEL_W < 1) $error("SEL_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         err <= 1'b0;
      end else if (we) begin
         sel <= din;
         if (din == RESERVED) err <= 1'b1;
      end
   end

   // R3: flag is sticky
   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R3: reserved write raises the flag
   assert_err_on_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && din == RESERVED) |=> err);
endmodule

// File: rtl/rbl_bank_map.sv
module rbl_bank_map #(
   parameter int unsigned SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             upper,
   output logic [SEL_W-1:0] bank
);
   localparam logic [SEL_W-1:0] TOP = '1;

   always_comb begin
      if (!upper)          bank = '0;
      else if (sel == TOP) bank = TOP;
      else                 bank = sel + 1'b1;
   end
endmodule

// File: rtl/rbl_ptr.sv
module rbl_ptr #(
   parameter int unsigned OFF_W = 12,
   parameter int unsigned NIB_W = 4,
   localparam int unsigned NIB_N = OFF_W / NIB_W,
   localparam int unsigned FLD_W = $clog2(NIB_N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [FLD_W-1:0] fld,
   input  logic [NIB_W-1:0] din,
   input  logic             inc,
   output logic [OFF_W-1:0] ptr
);
   initial begin
      if (OFF_W % NIB_W != 0) $error("OFF_W must be a multiple of NIB_W");
      if (NIB_N < 1) $error("pointer needs at least one nibble");
   end

   logic [OFF_W-1:0] loaded;

   for (genvar g = 0; g < NIB_N; g++) begin : g_nib
      always_comb begin
         if (fld == FLD_W'(g)) loaded[g*NIB_W +: NIB_W] = din;
         else                  loaded[g*NIB_W +: NIB_W] = ptr[g*NIB_W +: NIB_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (wr)  ptr <= loaded;
      else if (inc) ptr <= ptr + 1'b1;
   end

   // R7: increment by exactly one, wrapping
   assert_ptr_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr) |=> ptr == OFF_W'($past(ptr) + 1'b1));
   // R6: pointer holds without write or increment
   assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(ptr));
endmodule

// File: rtl/rbl_top.sv
module rbl_top
   import rbl_pkg::*;
#(
   parameter int unsigned SEL_W = RBL_SEL_W,
   parameter int unsigned OFF_W = RBL_OFF_W,
   parameter int unsigned NIB_W = RBL_NIB_W,
   localparam int unsigned CPU_W = OFF_W + 1,
   localparam int unsigned PA_W  = OFF_W + SEL_W,
   localparam int unsigned BYTE_W = 2 * NIB_W,
   localparam int unsigned FLD_W = $clog2(OFF_W / NIB_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [SEL_W-1:0]  bank_din,
   input  logic [CPU_W-1:0]  fetch_addr,
   output logic [PA_W-1:0]   fetch_paddr,
   input  logic              ptr_we,
   input  logic [FLD_W-1:0]  ptr_fld,
   input  logic [NIB_W-1:0]  ptr_din,
   input  logic              rd_lo,
   input  logic              rd_hi,
   output logic [PA_W-1:0]   tbl_paddr,
   input  logic [BYTE_W-1:0] tbl_data,
   output logic [NIB_W-1:0]  nib_out,
   output logic              bank_err
);
   logic [SEL_W-1:0] sel;
   logic [SEL_W-1:0] fetch_bank;
   logic [SEL_W-1:0] tbl_bank;
   logic [OFF_W-1:0] ptr;

   rbl_bank_reg #(.SEL_W(SEL_W)) bank_reg_i (
      .clk(clk), .rst_n(rst_n), .we(bank_we), .din(bank_din),
      .sel(sel), .err(bank_err));

   rbl_bank_map #(.SEL_W(SEL_W)) fetch_map_i (
      .sel(sel), .upper(fetch_addr[OFF_W]), .bank(fetch_bank));

   rbl_bank_map #(.SEL_W(SEL_W)) tbl_map_i (
      .sel(sel), .upper(1'b1), .bank(tbl_bank));

   rbl_ptr #(.OFF_W(OFF_W), .NIB_W(NIB_W)) ptr_i (
      .clk(clk), .rst_n(rst_n), .wr(ptr_we), .fld(ptr_fld), .din(ptr_din),
      .inc(rd_hi), .ptr(ptr));

   assign fetch_paddr = {fetch_bank, fetch_addr[OFF_W-1:0]};
   assign tbl_paddr   = {tbl_bank, ptr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     nib_out <= '0;
      else if (rd_hi) nib_out <= tbl_data[BYTE_W-1:NIB_W];
      else if (rd_lo) nib_out <= tbl_data[NIB_W-1:0];
   end

   // R5: table port never reaches bank 0
   assert_tbl_not_bank0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_paddr[PA_W-1:OFF_W] != '0);
   // R1: lower half stays in bank 0
   assert_lower_bank0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_addr[OFF_W] |-> fetch_paddr[PA_W-1:OFF_W] == '0);
   // R9: nibble output holds with no read
   assert_nib_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_lo && !rd_hi) |=> $stable(nib_out));
   // R7: high read does not move the bank
   assert_inc_keeps_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !bank_we) |=> $stable(tbl_paddr[PA_W-1:OFF_W]));
endmodule

// File: tb/rbl_top_tb_top.sv
`timescale 1ns/1ps
module rbl_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bank_we = 1'b0;
   logic [1:0]  bank_din = '0;
   logic [12:0] fetch_addr = '0;
   logic [13:0] fetch_paddr;
   logic        ptr_we = 1'b0;
   logic [1:0]  ptr_fld = '0;
   logic [3:0]  ptr_din = '0;
   logic        rd_lo = 1'b0;
   logic        rd_hi = 1'b0;
   logic [13:0] tbl_paddr;
   logic [7:0]  tbl_data;
   logic [3:0]  nib_out;
   logic        bank_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] rom(input logic [13:0] a);
      if (a == 14'h1777) return 8'h56;
      return a[7:0] ^ a[13:6] ^ 8'hA5;
   endfunction

   function automatic logic [1:0] bank_of(input logic [1:0] s);
      return (s == 2'd3) ? 2'd3 : s + 2'd1;
   endfunction

   assign tbl_data = rom(tbl_paddr);

   rbl_top dut_i (
      .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_din(bank_din),
      .fetch_addr(fetch_addr), .fetch_paddr(fetch_paddr),
      .ptr_we(ptr_we), .ptr_fld(ptr_fld), .ptr_din(ptr_din),
      .rd_lo(rd_lo), .rd_hi(rd_hi), .tbl_paddr(tbl_paddr),
      .tbl_data(tbl_data), .nib_out(nib_out), .bank_err(bank_err));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      bank_we = 0; ptr_we = 0; rd_lo = 0; rd_hi = 0;
   endtask

   task automatic set_bank(input logic [1:0] s);
      bank_we = 1; bank_din = s; tick();
   endtask

   task automatic wr_fld(input logic [1:0] f, input logic [3:0] v);
      ptr_we = 1; ptr_fld = f; ptr_din = v; tick();
   endtask

   task automatic set_ptr(input logic [11:0] v);
      wr_fld(2'd0, v[3:0]); wr_fld(2'd1, v[7:4]); wr_fld(2'd2, v[11:8]);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [11:0] p;
      logic [1:0]  bk;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      // R3 R4 R9 reset state
      check("R3 err reset", bank_err, 0);
      check("R4 ptr reset", tbl_paddr, 14'h1000);
      check("R9 nib reset", nib_out, 0);
      check("R2 reset bank", {31'd0, 1'b0} | fetch_paddr, 14'h1ABC & 14'h0 | 14'h0);
      fetch_addr = 13'h1ABC; #1;
      check("R2 reset upper bank1", fetch_paddr, 14'h1ABC);

      // R1 R2 R3 fetch sweep per select
      for (int s = 0; s < 4; s++) begin
         set_bank(2'(s));
         for (int a = 0; a < 8192; a += 29) begin
            fetch_addr = 13'(a); #0.5;
            if (a < 4096) check("R1 lower fetch", fetch_paddr, 14'(a));
            else check("R2 upper fetch", fetch_paddr, {bank_of(2'(s)), 12'(a)});
         end
         check("R5 tbl bank", tbl_paddr[13:12], bank_of(2'(s)));
         if (s < 3) check("R3 err clear", bank_err, 0);
         else       check("R3 err set", bank_err, 1);
      end
      set_bank(2'd0);
      check("R3 err sticky", bank_err, 1);
      fetch_addr = 13'h1000; #0.5;
      check("R2 after reserved", fetch_paddr, 14'h1000);

      // R4 field writes
      set_ptr(12'h000);
      wr_fld(2'd1, 4'hC);
      check("R4 mid field", tbl_paddr[11:0], 12'h0C0);
      wr_fld(2'd2, 4'h9);
      check("R4 high field", tbl_paddr[11:0], 12'h9C0);
      wr_fld(2'd0, 4'h3);
      check("R4 low field", tbl_paddr[11:0], 12'h9C3);
      wr_fld(2'd3, 4'hF);
      check("R4 code3 ignored", tbl_paddr[11:0], 12'h9C3);

      // R6 R7 worked byte
      set_ptr(12'h777);
      check("R5 tbl addr", tbl_paddr, 14'h1777);
      rd_lo = 1; tick();
      check("R6 low nibble", nib_out, 4'h6);
      check("R6 ptr unchanged", tbl_paddr, 14'h1777);
      tick();
      check("R9 hold", nib_out, 4'h6);
      rd_hi = 1; tick();
      check("R7 high nibble", nib_out, 4'h5);
      check("R7 ptr inc", tbl_paddr, 14'h1778);

      // R6 R7 streaming sweep over each select, crossing the wrap
      for (int s = 0; s < 3; s++) begin
         set_bank(2'(s));
         bk = bank_of(2'(s));
         p = 12'hF00;
         set_ptr(p);
         for (int i = 0; i < 400; i++) begin
            rd_lo = 1; tick();
            check("R6 stream low", nib_out, rom({bk, p}) & 8'h0F);
            rd_hi = 1; tick();
            check("R7 stream high", nib_out, rom({bk, p}) >> 4);
            p = p + 12'd1;
            check("R7 stream ptr", tbl_paddr, {bk, p});
         end
      end

      // R7 wrap boundary explicit
      set_bank(2'd2);
      set_ptr(12'hFFF);
      rd_hi = 1; tick();
      check("R7 wrap", tbl_paddr, 14'h3000);

      // R8 priorities
      set_ptr(12'h123);
      ptr_we = 1; ptr_fld = 2'd0; ptr_din = 4'h8; rd_hi = 1; tick();
      check("R8 write beats inc", tbl_paddr[11:0], 12'h128);
      check("R8 read still returns", nib_out, rom(14'h3123) >> 4);
      rd_hi = 1; rd_lo = 1; tick();
      check("R8 hi over lo", nib_out, rom(14'h3128) >> 4);
      check("R8 hi over lo ptr", tbl_paddr[11:0], 12'h129);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule